// File: doc/BRIEF.md
# Oversampled Serial Receiver with Majority Voting and Receive Queue

This block turns an asynchronous serial line into characters. A two-flop stage brings the line into the clock domain, and a free-running oversampling strobe (`tick`) paces the sampling at 16 or 8 samples per bit. Each bit value comes from a majority vote over the three samples in the middle of the bit. That includes the start bit, the optional parity bit and the stop bit. Accepted characters go into a small receive queue together with their parity-error and framing-error marks. The queue's output entry is presented to the consumer, which removes it with a one-cycle read strobe.

The block also recognises a line held low for a whole frame and reports it as a break. It signals when the break begins and again when the line returns high. When the break ends, a marker entry is queued. A hysteretic ready-to-receive output, active low, tells the remote sender to pause as the queue approaches full. A character that arrives while the queue is full is dropped and raises an overrun flag.

Top module: `serial_rx_mv`

## Requirements
- R1: After reset, `rd_valid`, `ovr_flag`, `brk_flag`, `brk_start`, `brk_end` and `rts_n` are all 0. A low excursion on `rx_in` that does not reach the start-bit voting window produces no character.
- R2: While idle, each tick checks the synchronized line. The first low sample is sample 0 of the start bit. Samples 1 to 6 (16x, `cfg_os8`=0) or 1 to 2 (8x, `cfg_os8`=1) are skipped, and the next three samples are voted. A majority of 0 accepts the start bit, and a majority of 1 returns the receiver to idle. A low pulse of exactly 9 samples (16x) or 5 samples (8x) followed by idle line is therefore accepted and yields an all-ones character.
- R3: Every start, data, parity and stop bit is decided by the majority of its samples 7, 8 and 9 (16x) or 3, 4 and 5 (8x), counted from the bit's first sample. One wrong sample inside that window does not change the result.
- R4: `cfg_bits` selects 5 to 9 data bits, and any other code means 8. Data bits above the configured length read as 0. With `cfg_msb_first`=0 the first received bit lands in `rd_data[0]`. With `cfg_msb_first`=1 it lands in bit `cfg_bits`-1.
- R5: With `cfg_par_en`=1 a parity bit follows the data. `cfg_par_kind` selects the expected value: 0 makes the total count of ones even, 1 makes it odd, 2 expects a constant 0, and 3 expects a constant 1. A mismatch sets the entry's `rd_perr`. With parity off, `rd_perr` is 0.
- R6: The frame ends right after the first stop bit is voted, and any further stop bits are not examined. A stop bit voted 0 sets the entry's `rd_ferr`.
- R7: Characters are queued first-in first-out, 4 entries deep. `rd_valid` is 1 while the output entry holds data. Asserting `rd_en` while `rd_valid`=1 removes the entry.
- R8: A character that completes while the queue is full and no entry is being removed is discarded and sets `ovr_flag`. `ovr_flag` clears on the next removal, and the queued entries are unchanged.
- R9: `rts_n` goes to 1 one cycle after occupancy reaches 3 and returns to 0 one cycle after occupancy falls to 2 or less.
- R10: A frame whose start, data, parity and stop bits all vote 0 is a break. It pulses `brk_start` and sets `brk_flag`, and no character is queued. The break ends at the second of two consecutive high samples. A single high sample does not end it. At the end, `brk_end` pulses once and an entry with `rd_data`=0, `rd_ferr`=1 and `rd_perr`=0 is queued.
- R11: `brk_flag` clears when an entry is removed or when a normal character is queued. `brk_flag`=1 with `rd_valid`=0 means a break is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling strobe, one cycle per sample |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_os8 | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| cfg_bits | input | 4 | Data bits per character (5 to 9) |
| cfg_msb_first | input | 1 | 1 when the first received bit is the most significant |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_kind | input | 2 | 0 even, 1 odd, 2 constant 0, 3 constant 1 |
| rd_en | input | 1 | Removes the output entry |
| rd_valid | output | 1 | Output entry holds a character |
| rd_data | output | 9 | Output entry data |
| rd_perr | output | 1 | Output entry parity error |
| rd_ferr | output | 1 | Output entry framing error |
| ovr_flag | output | 1 | A character was lost to a full queue |
| brk_flag | output | 1 | Break seen since the last removal or normal character |
| brk_start | output | 1 | One-cycle pulse when a break is recognised |
| brk_end | output | 1 | One-cycle pulse when a break ends |
| rts_n | output | 1 | Ready-to-receive, active low |

## Verification
The bench uses the default queue depth of 4 with release and hold levels of 3 and 2. Five back-to-back characters are therefore enough to fill the queue, trip `rts_n` and then overrun, and draining one entry at a time walks the hysteresis back down. The oversampling strobe comes every second clock and the line is driven on the same grid. This lets single-sample glitches and start pulses of exactly 5 or 9 samples land at known vote positions in both 8x and 16x modes. Randomly chosen lengths, bit orders, parity kinds and injected errors cover the data path.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DATA_W  = 9;
  localparam int BITS_W  = 4;
  localparam int PH_W    = 4;
  localparam int OS_WIDE = 16;
  localparam int OS_NARROW = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4,
    ST_BRK   = 3'd5
  } rx_state_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              perr;
    logic              ferr;
  } rx_entry_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_async};
  end

  // line idles high, so the chain resets to ones to avoid a false start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_s,
  input  logic              os8,
  input  logic [BITS_W-1:0] bits_cfg,
  input  logic              msb_first,
  input  logic              par_en,
  input  logic [1:0]        par_kind,
  output logic              push,
  output rx_entry_t         push_ent,
  output logic              push_brk,
  output logic              brk_start,
  output logic              brk_end
);
  rx_state_t         st, st_n;
  logic [PH_W-1:0]   ph, ph_n;
  logic [BITS_W-1:0] bidx, bidx_n;
  logic [1:0]        vcnt, vcnt_n;
  logic [DATA_W-1:0] sh, sh_n;
  logic              par_acc, par_n;
  logic              any1, any_n;
  logic              perr_r, perr_n;
  logic              hi_prev, hi_n;
  logic              push_n, pbrk_n, brks_n, brke_n;
  rx_entry_t         ent_n;

  logic [PH_W-1:0]   v_lo, v_hi, ph_last;
  logic [BITS_W-1:0] nb;
  logic [1:0]        vsum;
  logic              vote, par_exp;

  always_comb begin
    if (os8) begin
      v_lo    = PH_W'(OS_NARROW/2 - 1);
      v_hi    = PH_W'(OS_NARROW/2 + 1);
      ph_last = PH_W'(OS_NARROW - 1);
    end else begin
      v_lo    = PH_W'(OS_WIDE/2 - 1);
      v_hi    = PH_W'(OS_WIDE/2 + 1);
      ph_last = PH_W'(OS_WIDE - 1);
    end
    if (bits_cfg < BITS_W'(5) || bits_cfg > BITS_W'(DATA_W)) nb = BITS_W'(8);
    else                                                    nb = bits_cfg;
    case (par_kind)
      2'd0:    par_exp = par_acc;
      2'd1:    par_exp = ~par_acc;
      2'd2:    par_exp = 1'b0;
      default: par_exp = 1'b1;
    endcase
    vsum = vcnt + {1'b0, rx_s};
    vote = (vsum >= 2'd2);
  end

  always_comb begin
    st_n = st; ph_n = ph; bidx_n = bidx; vcnt_n = vcnt; sh_n = sh;
    par_n = par_acc; any_n = any1; perr_n = perr_r; hi_n = hi_prev;
    push_n = 1'b0; pbrk_n = push_brk; brks_n = 1'b0; brke_n = 1'b0;
    ent_n = push_ent;
    if (tick) begin
      if (st == ST_IDLE) begin
        if (!rx_s) begin
          st_n = ST_START; ph_n = PH_W'(1); vcnt_n = '0;
        end
      end else if (st == ST_BRK) begin
        hi_n = rx_s;
        if (rx_s && hi_prev) begin
          st_n = ST_IDLE; push_n = 1'b1; pbrk_n = 1'b1; brke_n = 1'b1;
          ent_n.data = '0; ent_n.perr = 1'b0; ent_n.ferr = 1'b1;
        end
      end else begin
        ph_n = (ph == ph_last) ? '0 : ph + PH_W'(1);
        if (ph >= v_lo && ph <= v_hi) vcnt_n = vsum;
        if (ph == v_hi) begin
          vcnt_n = '0;
          case (st)
            ST_START: begin
              if (vote) st_n = ST_IDLE;
              else begin
                st_n = ST_DATA; bidx_n = '0; sh_n = '0;
                par_n = 1'b0; any_n = 1'b0; perr_n = 1'b0;
              end
            end
            ST_DATA: begin
              sh_n   = msb_first ? {sh[DATA_W-2:0], vote} : {vote, sh[DATA_W-1:1]};
              par_n  = par_acc ^ vote;
              any_n  = any1 | vote;
              bidx_n = bidx + BITS_W'(1);
              if (bidx == nb - BITS_W'(1)) st_n = par_en ? ST_PAR : ST_STOP;
            end
            ST_PAR: begin
              perr_n = (vote != par_exp);
              any_n  = any1 | vote;
              st_n   = ST_STOP;
            end
            ST_STOP: begin
              if (any1 | vote) begin
                st_n = ST_IDLE; push_n = 1'b1; pbrk_n = 1'b0;
                ent_n.data = msb_first ? sh : (sh >> (BITS_W'(DATA_W) - nb));
                ent_n.perr = perr_r;
                ent_n.ferr = ~vote;
              end else begin
                st_n = ST_BRK; brks_n = 1'b1; hi_n = 1'b0;
              end
            end
            default: st_n = ST_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= '0; bidx <= '0; vcnt <= '0; sh <= '0;
      par_acc <= 1'b0; any1 <= 1'b0; perr_r <= 1'b0; hi_prev <= 1'b0;
      push <= 1'b0; push_brk <= 1'b0; brk_start <= 1'b0; brk_end <= 1'b0;
      push_ent <= '0;
    end else begin
      st <= st_n; ph <= ph_n; bidx <= bidx_n; vcnt <= vcnt_n; sh <= sh_n;
      par_acc <= par_n; any1 <= any_n; perr_r <= perr_n; hi_prev <= hi_n;
      push <= push_n; push_brk <= pbrk_n; brk_start <= brks_n; brk_end <= brke_n;
      push_ent <= ent_n;
    end
  end

  // R6
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && st == ST_STOP && ph == v_hi) |=> (st == ST_IDLE || st == ST_BRK));

  // R10
  brk_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_start |-> !push);

  // R2
  false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && st == ST_START && ph == v_hi && vote) |=> st == ST_IDLE);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  rx_entry_t     din,
  input  logic          rd,
  output rx_entry_t     dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  rx_entry_t       mem [DEPTH];
  logic [PW-1:0]   wp, rp, wp_n, rp_n;
  logic [CW-1:0]   cnt_n;
  logic            do_wr, do_rd;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rp];

  always_comb begin
    do_rd = rd && !empty;
    do_wr = wr && (!full || do_rd);
    wp_n  = wp;
    rp_n  = rp;
    if (do_wr) wp_n = (wp == PW'(DEPTH-1)) ? '0 : wp + PW'(1);
    if (do_rd) rp_n = (rp == PW'(DEPTH-1)) ? '0 : rp + PW'(1);
    cnt_n = count + CW'(do_wr) - CW'(do_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      wp <= wp_n; rp <= rp_n; count <= cnt_n;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       mem[i] <= '0;
      else if (do_wr && wp == PW'(i))   mem[i] <= din;
    end
  end

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !rd && !full) |=> count == $past(count) + CW'(1));
endmodule

// File: rtl/serial_rx_mv.sv
module serial_rx_mv
  import srx_pkg::*;
#(
  parameter int FIFO_DEPTH  = 4,
  parameter int RTS_OFF_LVL = 3,
  parameter int RTS_ON_LVL  = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_in,
  input  logic              cfg_os8,
  input  logic [3:0]        cfg_bits,
  input  logic              cfg_msb_first,
  input  logic              cfg_par_en,
  input  logic [1:0]        cfg_par_kind,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [8:0]        rd_data,
  output logic              rd_perr,
  output logic              rd_ferr,
  output logic              ovr_flag,
  output logic              brk_flag,
  output logic              brk_start,
  output logic              brk_end,
  output logic              rts_n
);
  logic          rx_s, f_push, f_brk, q_full, q_empty, pop;
  rx_entry_t     f_ent, q_out;
  logic [CW-1:0] q_cnt;
  logic          ovr_n, brk_n, rts_nx;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(rx_in), .q_sync(rx_s));

  srx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s), .os8(cfg_os8),
    .bits_cfg(cfg_bits), .msb_first(cfg_msb_first), .par_en(cfg_par_en),
    .par_kind(cfg_par_kind), .push(f_push), .push_ent(f_ent),
    .push_brk(f_brk), .brk_start(brk_start), .brk_end(brk_end));

  srx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr(f_push), .din(f_ent), .rd(rd_en),
    .dout(q_out), .full(q_full), .empty(q_empty), .count(q_cnt));

  assign pop      = rd_en && !q_empty;
  assign rd_valid = !q_empty;
  assign rd_data  = q_out.data;
  assign rd_perr  = q_out.perr;
  assign rd_ferr  = q_out.ferr;

  always_comb begin
    ovr_n = ovr_flag;
    if (pop)                      ovr_n = 1'b0;
    if (f_push && q_full && !pop) ovr_n = 1'b1;
    brk_n = brk_flag;
    if (pop || (f_push && !f_brk)) brk_n = 1'b0;
    if (brk_start)                 brk_n = 1'b1;
    rts_nx = rts_n;
    if (q_cnt >= CW'(RTS_OFF_LVL))     rts_nx = 1'b1;
    else if (q_cnt <= CW'(RTS_ON_LVL)) rts_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag <= 1'b0; brk_flag <= 1'b0; rts_n <= 1'b0;
    end else begin
      ovr_flag <= ovr_n; brk_flag <= brk_n; rts_n <= rts_nx;
    end
  end

  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_push && q_full && !rd_en) |=> ovr_flag);

  // R9
  rts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt >= CW'(RTS_OFF_LVL)) |=> rts_n);

  // R9
  rts_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt <= CW'(RTS_ON_LVL)) |=> !rts_n);

  // R10
  brk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_start |=> brk_flag);
endmodule

// File: tb/serial_rx_mv_test.sv
module serial_rx_mv_test;
  localparam int TDIV = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic tick;
  logic rx_in;
  logic cfg_os8, cfg_msb_first, cfg_par_en, rd_en;
  logic [3:0] cfg_bits;
  logic [1:0] cfg_par_kind;
  logic rd_valid, rd_perr, rd_ferr, ovr_flag, brk_flag, brk_start, brk_end, rts_n;
  logic [8:0] rd_data;

  int checks = 0;
  int fails = 0;
  int n_bs = 0;
  int n_be = 0;
  int tcnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always @(posedge clk) tcnt <= (tcnt == TDIV-1) ? 0 : tcnt + 1;
  assign tick = (tcnt == 0);

  always @(posedge clk) begin
    if (brk_start) n_bs++;
    if (brk_end)   n_be++;
  end

  serial_rx_mv uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_in), .cfg_os8(cfg_os8),
    .cfg_bits(cfg_bits), .cfg_msb_first(cfg_msb_first), .cfg_par_en(cfg_par_en),
    .cfg_par_kind(cfg_par_kind), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .ovr_flag(ovr_flag),
    .brk_flag(brk_flag), .brk_start(brk_start), .brk_end(brk_end), .rts_n(rts_n));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int os_n();
    return cfg_os8 ? 8 : 16;
  endfunction

  function automatic int nb_eff();
    return (cfg_bits < 5 || cfg_bits > 9) ? 8 : int'(cfg_bits);
  endfunction

  function automatic logic par_bit(input logic [8:0] d);
    logic x;
    x = 1'b0;
    for (int i = 0; i < nb_eff(); i++) x ^= d[i];
    case (cfg_par_kind)
      2'd0: return x;
      2'd1: return ~x;
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic samp(input logic lv, input int n);
    rx_in = lv;
    repeat (n * TDIV) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input bit g);
    if (g) begin
      samp(b, os_n()/2); samp(~b, 1); samp(b, os_n()/2 - 1);
    end else samp(b, os_n());
  endtask

  task automatic send_frame(input logic [8:0] d, input bit g, input bit badp, input bit bads);
    send_bit(1'b0, g);
    for (int i = 0; i < nb_eff(); i++)
      send_bit(cfg_msb_first ? d[nb_eff()-1-i] : d[i], g);
    if (cfg_par_en) send_bit(par_bit(d) ^ badp, g);
    send_bit(!bads, g);
    samp(1'b1, 2 * os_n());
  endtask

  task automatic pop();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_head(input string req, input int d, input int pe, input int fe);
    check({req, " valid"}, rd_valid, 1);
    check({req, " data"},  rd_data, d);
    check({req, " perr"},  rd_perr, pe);
    check({req, " ferr"},  rd_ferr, fe);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [8:0] d, m;
    int bs0, be0, inj;
    bit bp, bsf;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; rx_in = 1'b1; rd_en = 1'b0;
    cfg_os8 = 1'b0; cfg_bits = 4'd8; cfg_msb_first = 1'b0;
    cfg_par_en = 1'b0; cfg_par_kind = 2'd0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 reset valid", rd_valid, 0);
    check("R1 reset ovr",   ovr_flag, 0);
    check("R1 reset brk",   brk_flag, 0);
    check("R1 reset rts",   rts_n, 0);
    check("R1 reset pulses", brk_start | brk_end, 0);
    rst_n = 1'b1;
    samp(1'b1, 40);

    // R1 short glitch ignored
    samp(1'b0, 2); samp(1'b1, 60);
    check("R1 glitch no frame", rd_valid, 0);

    // R2 start window edges, both modes
    for (int mode = 0; mode < 2; mode++) begin
      cfg_os8 = mode[0];
      samp(1'b0, os_n()/2); samp(1'b1, 16 * os_n());
      check("R2 short start rejected", rd_valid, 0);
      samp(1'b0, os_n()/2 + 1); samp(1'b1, 16 * os_n());
      check_head("R2 minimal start accepted", 9'h0ff, 0, 0);
      pop();
    end
    cfg_os8 = 1'b0;

    // R3 one wrong sample in each vote window
    for (int mode = 0; mode < 2; mode++) begin
      cfg_os8 = mode[0]; cfg_par_en = 1'b1; cfg_par_kind = 2'd1;
      send_frame(9'h0a5, 1'b1, 1'b0, 1'b0);
      check_head("R3 glitched frame", 9'h0a5, 0, 0);
      pop();
    end
    cfg_os8 = 1'b0; cfg_par_en = 1'b0;

    // R4 MSB-first, 5 bits, and out-of-range length code
    cfg_bits = 4'd5; cfg_msb_first = 1'b1;
    send_frame(9'h013, 1'b0, 1'b0, 1'b0);
    check_head("R4 msb first 5b", 9'h013, 0, 0);
    pop();
    cfg_bits = 4'd15; cfg_msb_first = 1'b0;
    send_frame(9'h0c3, 1'b0, 1'b0, 1'b0);
    check_head("R4 invalid length code as 8", 9'h0c3, 0, 0);
    pop();

    // R7 R8 R9 fill, overrun and drain
    cfg_bits = 4'd8;
    for (int i = 0; i < 5; i++) begin
      send_frame(9'(8'h30 + i), 1'b0, 1'b0, 1'b0);
      if (i == 1) check("R9 rts low at 2", rts_n, 0);
      if (i == 2) check("R9 rts high at 3", rts_n, 1);
      if (i == 3) check("R8 no ovr at 4", ovr_flag, 0);
    end
    check("R8 ovr set", ovr_flag, 1);
    check("R9 rts high at full", rts_n, 1);
    for (int i = 0; i < 4; i++) begin
      check_head("R7 fifo order", 8'h30 + i, 0, 0);
      pop();
      if (i == 0) begin
        check("R8 ovr cleared by read", ovr_flag, 0);
        check("R9 rts still high at 3", rts_n, 1);
      end
      if (i == 1) check("R9 rts low at 2 after drain", rts_n, 0);
    end
    check("R7 empty after drain", rd_valid, 0);

    // R10 R11 break sequence
    bs0 = n_bs; be0 = n_be;
    samp(1'b0, 12 * os_n());
    check("R10 brk_start pulse", n_bs - bs0, 1);
    check("R11 brk in progress flag", brk_flag, 1);
    check("R11 brk in progress no data", rd_valid, 0);
    samp(1'b1, 1); samp(1'b0, 4);
    check("R10 single high not end", n_be - be0, 0);
    samp(1'b1, 2 * os_n());
    check("R10 brk_end pulse", n_be - be0, 1);
    check_head("R10 break entry", 0, 0, 1);
    check("R11 flag held after end", brk_flag, 1);
    pop();
    check("R11 flag cleared by read", brk_flag, 0);
    samp(1'b0, 12 * os_n()); samp(1'b1, 2 * os_n());
    check("R10 second break flag", brk_flag, 1);
    send_frame(9'h05a, 1'b0, 1'b0, 1'b0);
    check("R11 flag cleared by frame", brk_flag, 0);
    check_head("R10 break entry first", 0, 0, 1);
    pop();
    check_head("R7 frame after break", 9'h05a, 0, 0);
    pop();

    // R4 R5 R6 random frames
    for (int k = 0; k < 40; k++) begin
      cfg_os8 = 1'($urandom % 2);
      cfg_bits = 4'(5 + $urandom % 5);
      cfg_msb_first = 1'($urandom % 2);
      cfg_par_en = 1'($urandom % 2);
      cfg_par_kind = 2'($urandom % 4);
      m = 9'((1 << nb_eff()) - 1);
      d = 9'($urandom) & m;
      inj = $urandom % 5;
      bp = (inj == 0);
      bsf = (inj == 1);
      if (bsf) d = d | 9'h001;
      send_frame(d, 1'b0, bp, bsf);
      check_head("R4 R5 R6 random frame", d, int'(bp && cfg_par_en), int'(bsf));
      pop();
    end
    check("R7 empty at end", rd_valid, 0);
    finish_run();
  end
endmodule